// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block finds which physical frame holds a given (process ID, virtual page number) pair. The translation table behind it is inverted. It has exactly one entry per physical frame, and the frame number is the entry's index. Each entry records the owner process ID, the virtual page number currently resident in that frame, a valid flag and a link to the next entry. A small bucket-head memory maps each hash value to the first entry of its chain. Software builds the table and the chains. This block only reads them.

A request is accepted through a valid/ready handshake. The block hashes the pair, reads the bucket head, and then visits one chain entry per clock through a combinational read port. It compares both the process ID and the page number at each entry. The walk ends in one of three ways:
- a hit, which returns the entry index as the frame number;
- a not-found result at the end-of-chain marker;
- an error, when a link points outside the table or the walk visits as many entries as there are frames. A damaged or circular chain therefore cannot stall the requester.

Top module: `ipt_lookup`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid is 0.
- R2: The bucket index is the low 3 bits of (req_vpn XOR req_pid, with req_pid zero-extended). From the cycle after acceptance until the next acceptance, this index is presented on head_rd_addr.
- R3: An entry hits when its valid bit is 1 and both its stored process ID and stored page number equal the request. The response then carries status 1 (hit) and resp_frame equal to that entry's index.
- R4: An entry whose process ID matches but page number differs, or whose page number matches but process ID differs, does not hit. The walk continues to its link.
- R5: The link value 31 (all ones) is the end-of-chain marker. A head or link equal to 31 with no hit so far gives status 0 (not found) and resp_frame 0.
- R6: The block visits one entry per clock. Count clock edges after the accepting edge up to the first edge at which resp_valid is high:
  - 1 edge for a result decided at the bucket head;
  - k+2 edges for a hit on the entry at chain position k (counting from 0);
  - L+1 edges for a not-found result after L entries.
- R7: If 16 entries have been visited without a hit and the 16th entry's link is not 31, the walk stops with status 2 (error) and resp_frame 0, 17 edges after acceptance.
- R8: A head or link value from 16 to 30 is a broken pointer. It gives status 2 (error) as soon as it is read, and the entry it names is never read.
- R9: While resp_valid is 1 and resp_ready is 0, the status and frame stay unchanged and req_ready is 0. One edge with resp_ready at 1 drops resp_valid and raises req_ready.
- R10: An entry with its valid bit at 0 never hits, but its link is still followed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_pid | input | 4 | Process ID to look up |
| req_vpn | input | 10 | Virtual page number to look up |
| resp_valid | output | 1 | Result available |
| resp_ready | input | 1 | Requester takes the result |
| resp_status | output | 2 | 0 not found, 1 hit, 2 error |
| resp_frame | output | 4 | Frame number on a hit, else 0 |
| head_rd_addr | output | 3 | Bucket-head memory read address |
| head_rd_idx | input | 5 | First entry of the addressed bucket (31 = empty) |
| ent_rd_addr | output | 4 | Frame-entry memory read address |
| ent_rd_valid | input | 1 | Valid bit of the addressed entry |
| ent_rd_pid | input | 4 | Process ID stored in the addressed entry |
| ent_rd_vpn | input | 10 | Page number stored in the addressed entry |
| ent_rd_next | input | 5 | Link of the addressed entry (31 = end) |

## Verification
The lookup is tried with several kinds of input pattern, and each one tells a different fault apart:
- Empty buckets and hits on the chain head separate the head-decision path from the walking path.
- Three entries that collide in one bucket, looked up at each depth, catch a wrong hash, a link that is not followed, or a miscounted latency.
- Entries in the same bucket that share only the process ID, or only the page number, expose a comparison on one field alone.
- A cleared valid bit in mid-chain shows whether its link is still taken.
- A full 16-entry legal chain, set against a circular chain and out-of-range links, separates the end of a legal walk from the abort on the walk limit or a broken pointer.
- Randomly built tables with mixed present and absent pairs, and random response back-pressure, cover the remaining combinations.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_HEAD = 2'd1,
    WK_WALK = 2'd2,
    WK_RESP = 2'd3
  } wk_state_e;

  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_HIT  = 2'd1,
    LK_ERR  = 2'd2
  } lk_status_e;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W = 4,
  parameter int VPN_W = 10,
  parameter int BKT_W = 3
) (
  input  logic [PID_W-1:0] pid,
  input  logic [VPN_W-1:0] vpn,
  output logic [BKT_W-1:0] bucket
);

  logic [VPN_W-1:0] mixed;

  // fold the process ID into the page number, keep the low bucket bits
  assign mixed  = vpn ^ VPN_W'(pid);
  assign bucket = mixed[BKT_W-1:0];

endmodule

// File: rtl/ipt_entry_cmp.sv
module ipt_entry_cmp #(
  parameter int PID_W = 4,
  parameter int VPN_W = 10
) (
  input  logic [PID_W-1:0] key_pid,
  input  logic [VPN_W-1:0] key_vpn,
  input  logic             ent_valid,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0] ent_vpn,
  output logic             match
);

  assign match = ent_valid && (ent_pid == key_pid) && (ent_vpn == key_vpn);

endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int PID_W  = 4,
  parameter int VPN_W  = 10,
  parameter int FRAMES = 16,
  parameter int FRM_W  = 4,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic [PID_W-1:0] key_pid,
  output logic [VPN_W-1:0] key_vpn,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             ent_match,
  input  logic [IDX_W-1:0] ent_next,
  output logic [FRM_W-1:0] ent_addr,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [1:0]       resp_status,
  output logic [FRM_W-1:0] resp_frame
);

  localparam logic [IDX_W-1:0] NULL_IDX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] LIMIT    = IDX_W'(FRAMES);

  wk_state_e        st_q, st_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  lk_status_e       stat_q, stat_d;
  logic [FRM_W-1:0] frame_q, frame_d;
  logic             ld_key;
  logic             head_bad, next_bad, at_limit;

  assign head_bad = (head_idx >= LIMIT) && (head_idx != NULL_IDX);
  assign next_bad = (ent_next >= LIMIT) && (ent_next != NULL_IDX);
  assign at_limit = (cnt_q + 1'b1) == LIMIT;

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    stat_d  = stat_q;
    frame_d = frame_q;
    ld_key  = 1'b0;
    unique case (st_q)
      WK_IDLE: begin
        if (req_valid) begin
          ld_key = 1'b1;
          st_d   = WK_HEAD;
        end
      end
      WK_HEAD: begin
        cnt_d   = '0;
        frame_d = '0;
        if (head_idx == NULL_IDX) begin
          stat_d = LK_MISS;
          st_d   = WK_RESP;
        end else if (head_bad) begin
          stat_d = LK_ERR;
          st_d   = WK_RESP;
        end else begin
          cur_d = head_idx;
          st_d  = WK_WALK;
        end
      end
      WK_WALK: begin
        if (ent_match) begin
          stat_d  = LK_HIT;
          frame_d = cur_q[FRM_W-1:0];
          st_d    = WK_RESP;
        end else if (ent_next == NULL_IDX) begin
          stat_d = LK_MISS;
          st_d   = WK_RESP;
        end else if (next_bad || at_limit) begin
          stat_d = LK_ERR;
          st_d   = WK_RESP;
        end else begin
          cur_d = ent_next;
          cnt_d = cnt_q + 1'b1;
        end
      end
      WK_RESP: begin
        if (resp_ready) st_d = WK_IDLE;
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
      stat_q  <= LK_MISS;
      frame_q <= '0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
      frame_q <= frame_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q <= '0;
      vpn_q <= '0;
    end else if (ld_key) begin
      pid_q <= req_pid;
      vpn_q <= req_vpn;
    end
  end

  assign req_ready   = (st_q == WK_IDLE);
  assign resp_valid  = (st_q == WK_RESP);
  assign resp_status = stat_q;
  assign resp_frame  = frame_q;
  assign key_pid     = pid_q;
  assign key_vpn     = vpn_q;
  assign ent_addr    = cur_q[FRM_W-1:0];

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int PID_W   = 4,
  parameter int VPN_W   = 10,
  parameter int FRAMES  = 16,
  parameter int BUCKETS = 8,
  localparam int FRM_W  = $clog2(FRAMES),
  localparam int IDX_W  = $clog2(FRAMES) + 1,
  localparam int BKT_W  = $clog2(BUCKETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [1:0]       resp_status,
  output logic [FRM_W-1:0] resp_frame,
  output logic [BKT_W-1:0] head_rd_addr,
  input  logic [IDX_W-1:0] head_rd_idx,
  output logic [FRM_W-1:0] ent_rd_addr,
  input  logic             ent_rd_valid,
  input  logic [PID_W-1:0] ent_rd_pid,
  input  logic [VPN_W-1:0] ent_rd_vpn,
  input  logic [IDX_W-1:0] ent_rd_next
);

  logic [PID_W-1:0] key_pid;
  logic [VPN_W-1:0] key_vpn;
  logic             ent_match;

  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .BKT_W(BKT_W)) hash_i (
    .pid    (key_pid),
    .vpn    (key_vpn),
    .bucket (head_rd_addr)
  );

  ipt_entry_cmp #(.PID_W(PID_W), .VPN_W(VPN_W)) cmp_i (
    .key_pid   (key_pid),
    .key_vpn   (key_vpn),
    .ent_valid (ent_rd_valid),
    .ent_pid   (ent_rd_pid),
    .ent_vpn   (ent_rd_vpn),
    .match     (ent_match)
  );

  ipt_walker #(
    .PID_W(PID_W), .VPN_W(VPN_W), .FRAMES(FRAMES), .FRM_W(FRM_W), .IDX_W(IDX_W)
  ) walk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_pid     (req_pid),
    .req_vpn     (req_vpn),
    .key_pid     (key_pid),
    .key_vpn     (key_vpn),
    .head_idx    (head_rd_idx),
    .ent_match   (ent_match),
    .ent_next    (ent_rd_next),
    .ent_addr    (ent_rd_addr),
    .resp_valid  (resp_valid),
    .resp_ready  (resp_ready),
    .resp_status (resp_status),
    .resp_frame  (resp_frame)
  );

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAMES = 16,
  parameter int FRM_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic [1:0]       resp_status,
  input logic [FRM_W-1:0] resp_frame,
  input logic [FRM_W-1:0] ent_rd_addr
);

  logic [7:0] busy_cnt;
  logic       busy;

  assign busy = !req_ready && !resp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (req_valid && req_ready) begin
      busy_cnt <= '0;
    end else if (busy && busy_cnt != 8'hFF) begin
      busy_cnt <= busy_cnt + 8'd1;
    end
  end

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_status) && $stable(resp_frame));

  assert_no_accept_while_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  assert_hit_frame_is_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) && resp_status == 2'd1 |-> resp_frame == $past(ent_rd_addr));

  assert_miss_frame_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_status != 2'd1 |-> resp_frame == '0);

  assert_bounded_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt <= 8'(FRAMES + 1));

endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES), .FRM_W(FRM_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .resp_ready  (resp_ready),
  .resp_status (resp_status),
  .resp_frame  (resp_frame),
  .ent_rd_addr (ent_rd_addr)
);

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb_top;

  localparam int NF   = 16;
  localparam int NB   = 8;
  localparam logic [4:0] NUL = 5'd31;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [3:0] req_pid;
  logic [9:0] req_vpn;
  logic       resp_valid;
  logic       resp_ready;
  logic [1:0] resp_status;
  logic [3:0] resp_frame;
  logic [2:0] head_rd_addr;
  logic [4:0] head_rd_idx;
  logic [3:0] ent_rd_addr;
  logic       ent_rd_valid;
  logic [3:0] ent_rd_pid;
  logic [9:0] ent_rd_vpn;
  logic [4:0] ent_rd_next;

  logic [4:0] heads [NB];
  logic       ev    [NF];
  logic [3:0] epid  [NF];
  logic [9:0] evpn  [NF];
  logic [4:0] enext [NF];

  int n_tests;
  int n_fail;
  int cycles;

  assign head_rd_idx  = heads[head_rd_addr];
  assign ent_rd_valid = ev[ent_rd_addr];
  assign ent_rd_pid   = epid[ent_rd_addr];
  assign ent_rd_vpn   = evpn[ent_rd_addr];
  assign ent_rd_next  = enext[ent_rd_addr];

  ipt_lookup dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_status(resp_status), .resp_frame(resp_frame),
    .head_rd_addr(head_rd_addr), .head_rd_idx(head_rd_idx),
    .ent_rd_addr(ent_rd_addr), .ent_rd_valid(ent_rd_valid),
    .ent_rd_pid(ent_rd_pid), .ent_rd_vpn(ent_rd_vpn), .ent_rd_next(ent_rd_next)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      n_tests = n_tests + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [2:0] bkt(input logic [3:0] p, input logic [9:0] v);
    logic [9:0] x;
    x = v ^ {6'd0, p};
    return x[2:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests = n_tests + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] p, input logic [9:0] v,
                       output int st, output int fr, output int lat);
    logic [4:0] cur;
    int cnt;
    cur = heads[bkt(p, v)];
    lat = 1; fr = 0;
    if (cur == NUL) begin st = 0; return; end
    if (cur >= 5'd16) begin st = 2; return; end
    cnt = 0;
    forever begin
      lat = lat + 1;
      cnt = cnt + 1;
      if (ev[cur[3:0]] && epid[cur[3:0]] == p && evpn[cur[3:0]] == v) begin
        st = 1; fr = int'(cur); return;
      end
      if (enext[cur[3:0]] == NUL) begin st = 0; return; end
      if (enext[cur[3:0]] >= 5'd16 || cnt == NF) begin st = 2; return; end
      cur = enext[cur[3:0]];
    end
  endtask

  task automatic clear_table();
    for (int i = 0; i < NB; i++) heads[i] = NUL;
    for (int f = 0; f < NF; f++) begin
      ev[f] = 1'b0; epid[f] = '0; evpn[f] = '0; enext[f] = NUL;
    end
  endtask

  task automatic random_table();
    logic [2:0] b;
    clear_table();
    for (int f = 0; f < NF; f++) begin
      if ($urandom % 4 != 0) begin
        ev[f]   = 1'b1;
        epid[f] = 4'($urandom);
        evpn[f] = 10'($urandom % 64);
        b = bkt(epid[f], evpn[f]);
        enext[f] = heads[b];
        heads[b] = 5'(f);
      end
    end
  endtask

  task automatic lookup(input logic [3:0] p, input logic [9:0] v,
                        input string tag, input int hold);
    int est, efr, elat, n;
    model(p, v, est, efr, elat);
    @(negedge clk);
    req_valid = 1'b1; req_pid = p; req_vpn = v;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 head address"}, int'(head_rd_addr), int'(bkt(p, v)));
    n = 0;
    while (!resp_valid && n < 40) begin
      @(posedge clk); n = n + 1;
      @(negedge clk);
    end
    if (n == 0) n = 0;
    check({tag, " R6 latency"}, n, elat);
    check({tag, " R3/R5/R7/R8 status"}, int'(resp_status), est);
    check({tag, " R3 frame"}, int'(resp_frame), efr);
    repeat (hold) @(posedge clk);
    @(negedge clk);
    check({tag, " R9 held valid"}, int'(resp_valid), 1);
    check({tag, " R9 held status"}, int'(resp_status), est);
    check({tag, " R9 busy not ready"}, int'(req_ready), 0);
    resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    resp_ready = 1'b0;
    check({tag, " R9 released"}, int'(resp_valid), 0);
    check({tag, " R9 ready again"}, int'(req_ready), 1);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cycles = 0;
    void'($urandom(32'd4242));
    req_valid = 1'b0; req_pid = '0; req_vpn = '0; resp_ready = 1'b0;
    clear_table();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset req_ready", int'(req_ready), 1);
    check("R1 reset resp_valid", int'(resp_valid), 0);

    lookup(4'd3, 10'd5, "R5 empty bucket", 0);

    // bucket 3 chain: 9 -> 12 -> 5 -> end
    ev[5]  = 1; epid[5]  = 4'd1; evpn[5]  = 10'h002; enext[5]  = NUL;
    ev[12] = 1; epid[12] = 4'd1; evpn[12] = 10'h00A; enext[12] = 5'd5;
    ev[9]  = 1; epid[9]  = 4'd2; evpn[9]  = 10'h001; enext[9]  = 5'd12;
    heads[3] = 5'd9;
    lookup(4'd2, 10'h001, "R3 hit at head", 1);
    lookup(4'd1, 10'h00A, "R3 hit depth1", 0);
    lookup(4'd1, 10'h002, "R6 hit depth2", 2);
    lookup(4'd1, 10'h012, "R5 chain miss", 0);
    lookup(4'd2, 10'h009, "R4 pid only", 0);
    lookup(4'd9, 10'h00A, "R4 vpn only", 0);
    ev[12] = 0;
    lookup(4'd1, 10'h00A, "R10 invalid skip", 0);
    lookup(4'd1, 10'h002, "R10 link followed", 0);

    // full legal chain of 16 entries in bucket 0
    clear_table();
    for (int f = 0; f < NF; f++) begin
      ev[f] = 1; epid[f] = 4'd0; evpn[f] = 10'(8 * f);
      enext[f] = (f == NF - 1) ? NUL : 5'(f + 1);
    end
    heads[0] = 5'd0;
    lookup(4'd0, 10'd120, "R6 hit at 16th", 0);
    lookup(4'd0, 10'd128, "R7 full chain ends miss", 0);

    // circular chain
    clear_table();
    heads[0] = 5'd0; enext[0] = 5'd1; enext[1] = 5'd0;
    lookup(4'd0, 10'd0, "R7 circular chain", 1);

    // broken pointers
    clear_table();
    heads[0] = 5'd20;
    lookup(4'd0, 10'd0, "R8 bad head", 0);
    heads[0] = 5'd0; enext[0] = 5'd30;
    lookup(4'd0, 10'd0, "R8 bad link", 0);

    for (int t = 0; t < 300; t++) begin
      if (t % 20 == 0) random_table();
      if ($urandom % 2 == 0) begin
        int f;
        f = int'($urandom % NF);
        lookup(epid[f], evpn[f], "R3 random present", int'($urandom % 3));
      end else begin
        lookup(4'($urandom), 10'($urandom % 64), "R5 random pair", int'($urandom % 3));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule